// File: doc/BRIEF.md
# Sound-Memory Word DMA Engine

This block copies 16-bit words between a byte-wide sample RAM and the audio processor's internal register space. A host loads three 16-bit parameter registers and an interrupt-enable register through a small write port. Writing the control register with its execute bit set launches one transfer. The transfer can run in either direction, and a gate option writes zeros to the destination in place of source data. When the block finishes, the execute bit clears and, if enabled, an interrupt-pending flag is raised.

The parameter registers also sit inside register space, at `PRM_BASE`, `PRM_BASE+2` and `PRM_BASE+4`. A transfer from sample RAM into register space can therefore land on them. To prevent this, the engine saves all three registers before such a transfer and writes them back afterwards. The sequencer is one state machine with these states:

- `S_IDLE`: waits for a start.
- `S_SETUP`: latches the working counters and saves the parameters.
- `S_REG_RD` and `S_REG_CAP`: read one register-space word.
- `S_RAM_WLO` and `S_RAM_WHI`: write the two RAM bytes.
- `S_RAM_RLO`, `S_RAM_RHI` and `S_RAM_CAP`: read two RAM bytes.
- `S_REG_WR`: writes one register-space word.
- `S_FINISH`: restores the parameters, clears execute and raises the interrupt.

The transitions are:

- `S_IDLE` goes to `S_SETUP` on start.
- `S_SETUP` goes to `S_FINISH` when the length is zero. Otherwise it goes to the first state of a word.
- The first word state depends on direction and gate:
  - direction 1, no gate: `S_REG_RD`.
  - direction 1, gate: `S_RAM_WLO`.
  - direction 0, no gate: `S_RAM_RLO`.
  - direction 0, gate: `S_REG_WR`.
- Each state of a word steps to the next state of that word.
- The last state of a word (`S_RAM_WHI` or `S_REG_WR`) returns to the first state of a word. After the final word it goes to `S_FINISH` instead.
- `S_FINISH` goes to `S_IDLE`.

Top module: `smd_dma_top`

## Requirements
- R1: After reset, `busy` and `irq_pend` are 0, all four host-readable registers read 0, and no RAM or register-space strobe is active while `busy` is 0.
- R2: Host select codes are 0 = address-low register, 1 = address-high register, 2 = control register, 3 = interrupt-enable register. The RAM start address is {address-high[15:12], address-low[15:1], 0}. The register-space start address is {address-high[11:1], 0}. The byte length is {control[11:1], 0}.
- R3: With control bit 13 (direction) = 1 and bit 14 (gate) = 0, word k is read from register space at start+2k. Its low byte is written to RAM address start+2k and its high byte to start+2k+1, both addresses wrapping within 20 bits.
- R4: With direction = 0 and gate = 0, word k is formed from RAM bytes (start+2k) as the low byte and (start+2k+1) as the high byte. It is written to register space at start+2k, wrapping within 12 bits.
- R5: With gate = 1, every destination write carries 0, no source read takes place, and only the destination address advances.
- R6: With direction = 0, the three parameter registers read back after completion exactly as they were at start, with only the execute bit cleared. This holds even if the transfer wrote their register-space addresses.
- R7: Control bit 12 (execute) clears by itself at completion in both directions.
- R8: At completion `irq_pend` is set if interrupt-enable bit 4 is 1. It stays set until `irq_ack`. A completion and an acknowledge in the same cycle leave it set.
- R9: `busy` rises in the cycle after the starting control write and lasts 2 + W*k cycles, where W is the word count. k is 4 without gate, 2 for gated direction 1 and 1 for gated direction 0.
- R10: Host writes to the three parameter registers are ignored while `busy` is 1, including a second start.
- R11: A zero length makes no RAM or register-space access, keeps `busy` for 2 cycles, clears execute and can still raise `irq_pend`.
- R12: Writing the control register with execute = 0 stores the value and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 2 | Host write register select |
| hw_data | input | 16 | Host write data |
| hr_sel | input | 2 | Host read register select |
| hr_data | output | 16 | Host read data (combinational) |
| irq_ack | input | 1 | Clears the DMA-end pending flag |
| irq_pend | output | 1 | DMA-end interrupt pending |
| busy | output | 1 | Transfer in progress |
| sm_addr | output | MA_W | Sample RAM byte address |
| sm_re | output | 1 | Sample RAM read request; data returns next cycle |
| sm_we | output | 1 | Sample RAM byte write |
| sm_wdata | output | 8 | Sample RAM write byte |
| sm_rdata | input | 8 | Sample RAM read byte |
| rf_addr | output | RA_W | Register-space byte address (even) |
| rf_re | output | 1 | Register-space read request; data returns next cycle |
| rf_we | output | 1 | Register-space word write |
| rf_wdata | output | 16 | Register-space write word |
| rf_rdata | input | 16 | Register-space read word |

## Verification
Two events can fall in the same clock edge: the raising of the pending flag at the end of a transfer, and the host's acknowledge that clears it. The bench computes the exact busy length from the word count, direction and gate. It then drives `irq_ack` for the one edge that closes `S_FINISH`, in random and directed runs. Afterwards it judges the flag: set if interrupt-enable bit 4 was 1, cleared otherwise.

// File: rtl/smd_pkg.sv
package smd_pkg;
    localparam int PRM_N    = 3;
    localparam int BIT_EXEC = 12;
    localparam int BIT_DIR  = 13;
    localparam int BIT_GATE = 14;
    localparam int BIT_IEN  = 4;

    localparam logic [1:0] SEL_ALO = 2'd0;
    localparam logic [1:0] SEL_AHI = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;
    localparam logic [1:0] SEL_IEN = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_REG_RD, S_REG_CAP, S_RAM_WLO, S_RAM_WHI,
        S_RAM_RLO, S_RAM_RHI, S_RAM_CAP, S_REG_WR, S_FINISH
    } smd_state_t;
endpackage

// File: rtl/smd_regs.sv
module smd_regs
    import smd_pkg::*;
#(
    parameter int RA_W = 12,
    parameter logic [RA_W-1:0] PRM_BASE = 'h080
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_en,
    input  logic [1:0]             hw_sel,
    input  logic [15:0]            hw_data,
    input  logic [1:0]             hr_sel,
    output logic [15:0]            hr_data,
    input  logic                   irq_ack,
    output logic                   irq_pend,
    input  logic                   busy,
    input  logic                   save_en,
    input  logic                   fin,
    input  logic                   restore_en,
    input  logic                   snoop_we,
    input  logic [RA_W-1:0]        snoop_addr,
    input  logic [15:0]            snoop_data,
    output logic                   start,
    output logic [PRM_N-1:0][15:0] prm
);
    logic [PRM_N-1:0][15:0] saved;
    logic [15:0]            ien;

    assign start = hw_en && !busy && (hw_sel == SEL_CTL) && hw_data[BIT_EXEC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prm   <= '0;
            saved <= '0;
            ien   <= '0;
        end else begin
            if (hw_en && hw_sel == SEL_IEN)
                ien <= hw_data;
            if (hw_en && !busy && hw_sel != SEL_IEN)
                prm[hw_sel] <= hw_data;
            if (snoop_we) begin
                for (int i = 0; i < PRM_N; i++)
                    if (snoop_addr == PRM_BASE + RA_W'(2 * i))
                        prm[i] <= snoop_data;
            end
            if (save_en)
                saved <= prm;
            if (fin) begin
                if (restore_en) begin
                    for (int i = 0; i < PRM_N - 1; i++)
                        prm[i] <= saved[i];
                    prm[PRM_N-1] <= saved[PRM_N-1] & ~(16'h1 << BIT_EXEC);
                end else begin
                    prm[PRM_N-1][BIT_EXEC] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pend <= 1'b0;
        else if (fin && ien[BIT_IEN])
            irq_pend <= 1'b1;
        else if (irq_ack)
            irq_pend <= 1'b0;
    end

    always_comb begin
        unique case (hr_sel)
            SEL_ALO: hr_data = prm[0];
            SEL_AHI: hr_data = prm[1];
            SEL_CTL: hr_data = prm[2];
            default: hr_data = ien;
        endcase
    end
endmodule

// File: rtl/smd_seq.sv
module smd_seq
    import smd_pkg::*;
#(
    parameter int MA_W = 20,
    parameter int RA_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PRM_N-1:0][15:0] prm,
    output logic                   busy,
    output logic                   save_en,
    output logic                   fin,
    output logic                   restore_en,
    output logic [MA_W-1:0]        sm_addr,
    output logic                   sm_re,
    output logic                   sm_we,
    output logic [7:0]             sm_wdata,
    input  logic [7:0]             sm_rdata,
    output logic [RA_W-1:0]        rf_addr,
    output logic                   rf_re,
    output logic                   rf_we,
    output logic [15:0]            rf_wdata,
    input  logic [15:0]            rf_rdata
);
    localparam int HI_W = MA_W - 16;

    smd_state_t        st, st_nx;
    logic [MA_W-1:0]   mea;
    logic [RA_W-1:0]   rga, len_q, cnt;
    logic [RA_W-1:0]   len_new, cnt_nx;
    logic              dir_q, gate_q, last;
    logic [15:0]       hold;

    assign len_new = {prm[2][RA_W-1:1], 1'b0};
    assign cnt_nx  = cnt + RA_W'(2);
    assign last    = (cnt_nx == len_q);

    function automatic smd_state_t word_head(input logic dir, input logic gate);
        if (dir) return gate ? S_RAM_WLO : S_REG_RD;
        else     return gate ? S_REG_WR  : S_RAM_RLO;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (start) st_nx = S_SETUP;
            S_SETUP:   st_nx = (len_new == '0) ? S_FINISH
                               : word_head(prm[2][BIT_DIR], prm[2][BIT_GATE]);
            S_REG_RD:  st_nx = S_REG_CAP;
            S_REG_CAP: st_nx = S_RAM_WLO;
            S_RAM_WLO: st_nx = S_RAM_WHI;
            S_RAM_RLO: st_nx = S_RAM_RHI;
            S_RAM_RHI: st_nx = S_RAM_CAP;
            S_RAM_CAP: st_nx = S_REG_WR;
            S_RAM_WHI,
            S_REG_WR:  st_nx = last ? S_FINISH : word_head(dir_q, gate_q);
            S_FINISH:  st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy       = (st != S_IDLE);
        save_en    = (st == S_SETUP) && !prm[2][BIT_DIR];
        fin        = (st == S_FINISH);
        restore_en = fin && !dir_q;
        sm_re      = (st == S_RAM_RLO) || (st == S_RAM_RHI);
        sm_we      = (st == S_RAM_WLO) || (st == S_RAM_WHI);
        sm_addr    = (st == S_RAM_WHI || st == S_RAM_RHI) ? {mea[MA_W-1:1], 1'b1} : mea;
        sm_wdata   = (st == S_RAM_WHI) ? hold[15:8] : hold[7:0];
        rf_re      = (st == S_REG_RD);
        rf_we      = (st == S_REG_WR);
        rf_addr    = rga;
        rf_wdata   = hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mea <= '0; rga <= '0; len_q <= '0; cnt <= '0;
            dir_q <= 1'b0; gate_q <= 1'b0; hold <= '0;
        end else begin
            unique case (st)
                S_SETUP: begin
                    mea    <= {prm[1][15 -: HI_W], prm[0][15:1], 1'b0};
                    rga    <= {prm[1][RA_W-1:1], 1'b0};
                    len_q  <= len_new;
                    cnt    <= '0;
                    dir_q  <= prm[2][BIT_DIR];
                    gate_q <= prm[2][BIT_GATE];
                    hold   <= '0;
                end
                S_REG_CAP: hold       <= rf_rdata;
                S_RAM_RHI: hold[7:0]  <= sm_rdata;
                S_RAM_CAP: hold[15:8] <= sm_rdata;
                S_RAM_WHI, S_REG_WR: begin
                    cnt <= cnt_nx;
                    if (dir_q || !gate_q)  mea <= mea + MA_W'(2);
                    if (!dir_q || !gate_q) rga <= rga + RA_W'(2);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smd_dma_top.sv
module smd_dma_top
    import smd_pkg::*;
#(
    parameter int MA_W = 20,
    parameter int RA_W = 12,
    parameter logic [RA_W-1:0] PRM_BASE = 'h080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_en,
    input  logic [1:0]      hw_sel,
    input  logic [15:0]     hw_data,
    input  logic [1:0]      hr_sel,
    output logic [15:0]     hr_data,
    input  logic            irq_ack,
    output logic            irq_pend,
    output logic            busy,
    output logic [MA_W-1:0] sm_addr,
    output logic            sm_re,
    output logic            sm_we,
    output logic [7:0]      sm_wdata,
    input  logic [7:0]      sm_rdata,
    output logic [RA_W-1:0] rf_addr,
    output logic            rf_re,
    output logic            rf_we,
    output logic [15:0]     rf_wdata,
    input  logic [15:0]     rf_rdata
);
    logic                   start, save_en, fin, restore_en;
    logic [PRM_N-1:0][15:0] prm;

    smd_regs #(.RA_W(RA_W), .PRM_BASE(PRM_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
        .hr_sel(hr_sel), .hr_data(hr_data), .irq_ack(irq_ack), .irq_pend(irq_pend),
        .busy(busy), .save_en(save_en), .fin(fin), .restore_en(restore_en),
        .snoop_we(rf_we), .snoop_addr(rf_addr), .snoop_data(rf_wdata),
        .start(start), .prm(prm)
    );

    smd_seq #(.MA_W(MA_W), .RA_W(RA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .prm(prm), .busy(busy),
        .save_en(save_en), .fin(fin), .restore_en(restore_en),
        .sm_addr(sm_addr), .sm_re(sm_re), .sm_we(sm_we), .sm_wdata(sm_wdata),
        .sm_rdata(sm_rdata), .rf_addr(rf_addr), .rf_re(rf_re), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );
endmodule

// File: rtl/smd_dma_chk.sv
module smd_dma_chk #(
    parameter int MA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hw_en,
    input logic [1:0]      hw_sel,
    input logic [15:0]     hw_data,
    input logic            irq_ack,
    input logic            irq_pend,
    input logic            busy,
    input logic [MA_W-1:0] sm_addr,
    input logic            sm_re,
    input logic            sm_we,
    input logic [7:0]      sm_wdata,
    input logic            rf_re,
    input logic            rf_we,
    input logic [15:0]     rf_wdata
);
    logic gate_l;
    logic launch;

    assign launch = hw_en && !busy && hw_sel == 2'd2 && hw_data[12];

    always_ff @(posedge clk) begin
        if (!rst_n)      gate_l <= 1'b0;
        else if (launch) gate_l <= hw_data[14];
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sm_re || sm_we || rf_re || rf_we)); // R1
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sm_re, sm_we, rf_re, rf_we}) <= 1); // R3
    AST_ODD_FOLLOWS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_we && !sm_addr[0]) |=> (sm_we && sm_addr[0] && sm_addr[MA_W-1:1] == $past(sm_addr[MA_W-1:1]))); // R3
    AST_GATE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gate_l && (sm_we || rf_we)) |-> (sm_wdata == 8'h00 && rf_wdata == 16'h0000)); // R5
    AST_GATE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gate_l) |-> (!sm_re && !rf_re)); // R5
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch)); // R9
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_ack) |=> irq_pend); // R8
    AST_PEND_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(busy)); // R8
endmodule

bind smd_dma_top smd_dma_chk #(.MA_W(MA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .busy(busy), .sm_addr(sm_addr),
    .sm_re(sm_re), .sm_we(sm_we), .sm_wdata(sm_wdata), .rf_re(rf_re),
    .rf_we(rf_we), .rf_wdata(rf_wdata)
);

// File: tb/smd_dma_top_tb_top.sv
module smd_dma_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MA_W = 20;
    localparam int RA_W = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hw_en = 1'b0;
    logic [1:0]      hw_sel = '0;
    logic [15:0]     hw_data = '0;
    logic [1:0]      hr_sel = '0;
    logic [15:0]     hr_data;
    logic            irq_ack = 1'b0;
    logic            irq_pend, busy;
    logic [MA_W-1:0] sm_addr;
    logic            sm_re, sm_we, rf_re, rf_we;
    logic [7:0]      sm_wdata;
    logic [7:0]      sm_rdata = '0;
    logic [RA_W-1:0] rf_addr;
    logic [15:0]     rf_wdata;
    logic [15:0]     rf_rdata = '0;

    int checks = 0, errors = 0, cyc = 0;
    int n_smw = 0, n_rfw = 0, n_rd = 0;
    logic [7:0]  ram_m [int unsigned];
    logic [15:0] reg_m [int unsigned];
    logic [7:0]  sm_pipe = '0;
    logic [15:0] rf_pipe = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smd_dma_top dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
        .hr_sel(hr_sel), .hr_data(hr_data), .irq_ack(irq_ack), .irq_pend(irq_pend),
        .busy(busy), .sm_addr(sm_addr), .sm_re(sm_re), .sm_we(sm_we),
        .sm_wdata(sm_wdata), .sm_rdata(sm_rdata), .rf_addr(rf_addr), .rf_re(rf_re),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] ram_rd(input logic [MA_W-1:0] a);
        int unsigned k = int'(a);
        if (ram_m.exists(k)) return ram_m[k];
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] reg_rd(input logic [RA_W-1:0] a);
        int unsigned k = int'(a);
        if (reg_m.exists(k)) return reg_m[k];
        return {a[7:0] ^ 8'hC3, a[11:4] ^ 8'h1E};
    endfunction

    // Environment models: read data returns one cycle after the request.
    always @(negedge clk) begin
        sm_rdata = sm_pipe;
        rf_rdata = rf_pipe;
        sm_pipe  = sm_re ? ram_rd(sm_addr) : 8'h00;
        rf_pipe  = rf_re ? reg_rd(rf_addr) : 16'h0000;
        if (sm_re || rf_re) n_rd++;
        if (sm_we) begin ram_m[int'(sm_addr)] = sm_wdata; n_smw++; end
        if (rf_we) begin reg_m[int'(rf_addr)] = rf_wdata; n_rfw++; end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog act %0d exp <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = sel; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic logic [15:0] hrd(input logic [1:0] sel);
        hr_sel = sel;
        return hr_data;
    endfunction

    task automatic read_reg(input logic [1:0] sel, output logic [15:0] v);
        hr_sel = sel;
        #1;
        v = hr_data;
    endtask

    // One transfer: program, launch, count busy, then judge everything.
    task automatic xfer(input logic [15:0] p0, input logic [15:0] p1, input int words,
                        input bit dir, input bit gate, input bit ien4,
                        input bit collide, input bit poke);
        logic [MA_W-1:0] mea;
        logic [RA_W-1:0] rga;
        logic [15:0] p2, rd, exp_w [8];
        int exp_n, cnt, mism;
        logic [31:0] bad_a, bad_e;
        bit pend0, exp_pend;
        p2  = 16'(2 * words) | (16'(dir) << 13) | (16'(gate) << 14) | 16'h1000;
        mea = {p1[15:12], p0[15:1], 1'b0};
        rga = {p1[11:1], 1'b0};
        hwr(2'd3, ien4 ? 16'h0010 : 16'h0000);
        hwr(2'd0, p0);
        hwr(2'd1, p1);
        for (int k = 0; k < words; k++) begin
            if (gate) exp_w[k] = 16'h0000;
            else if (dir) exp_w[k] = reg_rd(rga + RA_W'(2 * k));
            else exp_w[k] = {ram_rd(mea + MA_W'(2 * k + 1)), ram_rd(mea + MA_W'(2 * k))};
        end
        exp_n = (words == 0) ? 2 : 2 + words * (gate ? (dir ? 2 : 1) : 4);
        pend0 = irq_pend;
        n_smw = 0; n_rfw = 0; n_rd = 0;
        @(negedge clk);
        hw_en = 1'b1; hw_sel = 2'd2; hw_data = p2;
        @(negedge clk);
        hw_en = 1'b0;
        cnt = 0;
        while (busy && cnt < 200) begin
            cnt++;
            irq_ack = collide && (cnt == exp_n);
            if (poke && cnt == 2) begin
                hw_en = 1'b1; hw_sel = 2'd0; hw_data = 16'hFFFF;
            end else if (poke && cnt == 3) begin
                hw_sel = 2'd2; hw_data = 16'h7FFE;
            end else begin
                hw_en = 1'b0;
            end
            @(negedge clk);
        end
        irq_ack = 1'b0; hw_en = 1'b0;
        chk(cnt == exp_n, "R9 busy length", cnt, exp_n);
        mism = 0; bad_a = 0; bad_e = 0;
        for (int k = 0; k < words; k++) begin
            logic [15:0] got;
            if (dir) got = {ram_rd(mea + MA_W'(2 * k + 1)), ram_rd(mea + MA_W'(2 * k))};
            else     got = reg_rd(rga + RA_W'(2 * k));
            if (got !== exp_w[k]) begin
                if (mism == 0) begin bad_a = {16'(k), got}; bad_e = {16'(k), exp_w[k]}; end
                mism++;
            end
        end
        if (gate) chk(mism == 0, "R5 gate zero fill", bad_a, bad_e);
        else if (dir) chk(mism == 0, "R3 reg-to-ram data", bad_a, bad_e);
        else chk(mism == 0, "R4 ram-to-reg data", bad_a, bad_e);
        if (words == 0)
            chk(n_smw + n_rfw + n_rd == 0, "R11 zero length no access", n_smw + n_rfw + n_rd, 0);
        else if (dir)
            chk(n_smw == 2 * words && n_rfw == 0, "R3 RAM write count", n_smw, 2 * words);
        else
            chk(n_rfw == words && n_smw == 0, "R4 reg write count", n_rfw, words);
        if (gate) chk(n_rd == 0, "R5 no source reads", n_rd, 0);
        read_reg(2'd2, rd);
        chk(rd == (p2 & 16'hEFFF), "R7 execute self-clear", rd, p2 & 16'hEFFF);
        if (!poke) begin
            read_reg(2'd0, rd);
            chk(rd == p0, dir ? "R2 addr-low kept" : "R6 addr-low restored", rd, p0);
            read_reg(2'd1, rd);
            chk(rd == p1, dir ? "R2 addr-high kept" : "R6 addr-high restored", rd, p1);
        end else begin
            read_reg(2'd0, rd);
            chk(rd == p0, "R10 busy write ignored", rd, p0);
            #(CLK_PERIOD * 3);
            chk(!busy, "R10 no restart while busy", busy, 0);
        end
        exp_pend = ien4 ? 1'b1 : (collide ? 1'b0 : pend0);
        chk(irq_pend == exp_pend, collide ? "R8 done-ack collision" : "R8 pending flag",
            irq_pend, exp_pend);
    endtask

    initial begin : main
        logic [15:0] v;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        #1;
        read_reg(2'd0, v); chk(v == 0, "R1 reset addr-low", v, 0);
        read_reg(2'd2, v); chk(v == 0, "R1 reset control", v, 0);
        read_reg(2'd3, v); chk(v == 0, "R1 reset ien", v, 0);
        chk(!busy && !irq_pend, "R1 reset busy/pend", {busy, irq_pend}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: control without execute stores only
        hwr(2'd2, 16'h2006);
        repeat (2) @(negedge clk);
        chk(!busy, "R12 no start without execute", busy, 0);
        read_reg(2'd2, v); chk(v == 16'h2006, "R12 control stored", v, 16'h2006);

        // directed corners
        xfer(16'h1235, 16'hA207, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R2 odd bits dropped, R3
        xfer(16'h4000, 16'h3204, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R4
        xfer(16'h0000, 16'h007C, 6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R6 overwrites params
        xfer(16'h0100, 16'h0300, 0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R11 with R8 collision
        xfer(16'h2000, 16'h5500, 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R5 gate dir1
        xfer(16'h3000, 16'h0600, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R5 gate dir0, R8
        xfer(16'hFFFC, 16'hFFFC, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R3 wrap both spaces
        xfer(16'hFFFC, 16'h0FFC, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R4 wrap
        xfer(16'h0800, 16'h0400, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R10 poke while busy

        for (int i = 0; i < 30; i++) begin
            logic [15:0] r0, r1;
            r0 = 16'($urandom());
            r1 = 16'($urandom());
            r1[11:0] = 12'h200 + 12'($urandom_range(0, 12'hC00));
            xfer(r0, r1, $urandom_range(0, 6), 1'($urandom()), 1'($urandom()),
                 1'($urandom()), ($urandom_range(0, 3) == 0), 1'b0);
            if ($urandom_range(0, 2) == 0) begin
                @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
                chk(!irq_pend, "R8 ack clears", irq_pend, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule